// File: doc/BRIEF.md
# Two-Speed Processor Clock Generator

This block makes every processor clock from one master clock running at sixteen times the 1 MHz rate. A free-running binary divider provides the 8, 4, 2 and 1 MHz taps. A 2 MHz system clock and a 1 MHz system clock, shifted a quarter period from the raw 1 MHz tap, come from those taps. The processor itself gets a two-phase clock, phi1 and phi2, that never overlaps. A dead master cycle separates the two phases at every edge.

Normally the processor cycle lasts one 2 MHz period, with phi2 high while the 2 MHz tap is low. When the address decode pulls any of its active-low slow-device selects low, the cycle is stretched. Phi2 is held high across one full high phase of the 1 MHz system clock and drops on the same master edge as that clock does. The slow devices are the 1 MHz expansion pages, the ADC, the VIAs, the CRT controller, the ACIA and the serial processor. Which of two sequences runs depends on the phase of the 1 MHz clock when the request is seen.

Top module: `cpu_clock_stretcher`

## Requirements
- R1: `divTaps` is 0 in reset and increases by one (mod 2^CNT_W) on every master edge afterwards. Bit k is the divide-by-2^(k+1) tap, so bit 0 is 8 MHz and bit 3 is 1 MHz at the default width.
- R2: `sysClk2` is high exactly when `divTaps` bit 2 is high. `sysClk1` is high exactly while `divTaps` is in 4..11, so it rises at count 4 and falls at count 12.
- R3: With no request, phi2 is high for divider phase (`divTaps` bits 2:0) 1, 2, 3 and phi1 for phase 5, 6, 7. This gives an 8-cycle processor cycle with phi2 rising at phase 1 and falling at phase 4.
- R4: phi1 and phi2 are never high together. On the master cycle after either one falls, the other is still low.
- R5: A slow request is any `slowSelN` bit at 0. It is sampled only on the edge that starts phi1 (phase becoming 5). A select that goes low after that edge and is released before the next sampling edge leaves the cycle at 8 master cycles.
- R6: A request sampled when the count becomes 13 (`sysClk1` low) gives phi2 rising at count 1 and held for 11 cycles. It falls at count 12 on the same edge as `sysClk1`, so the processor cycle is 16 master cycles (1 µs).
- R7: A request sampled when the count becomes 5 (`sysClk1` high) gives phi2 rising at count 9 and held for 19 cycles, through the next full `sysClk1` high phase. It falls together with `sysClk1` at count 12, so the processor cycle is 24 master cycles.
- R8: phi1 stays low for the whole of a stretched phi2. After the shared fall, phi1 rises again at count 13, back on the normal phase grid.
- R9: While `rstN` is low, phi1, phi2, `sysClk1`, `sysClk2` and `divTaps` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (16 x the 1 MHz rate) |
| rstN | input | 1 | Asynchronous active-low reset |
| slowSelN | input | NUM_SEL | Active-low slow-device selects |
| divTaps | output | CNT_W | Divider taps, bit 0 fastest |
| phi1 | output | 1 | Processor clock phase 1 |
| phi2 | output | 1 | Processor clock phase 2 |
| sysClk2 | output | 1 | 2 MHz system clock |
| sysClk1 | output | 1 | Phase-shifted 1 MHz system clock |

## Verification
The bench builds the block at the default CNT_W of 4 and NUM_SEL of 6. At that width the 1 MHz period is sixteen master cycles, so both entry phases, counts 5 and 13, are reached within a few processor cycles. The request sequence alternates fast and slow cycles so that stretches start from each phase. Slow and glitching requests are spread over all six select lines. Every phi2 pulse is compared against the count at which it should rise, its length, and whether it falls with the 1 MHz clock.

// File: rtl/cpu_clock_stretcher_pkg.sv
package cpu_clock_stretcher_pkg;
  // Next-edge values of the two processor phases, from control to datapath.
  typedef struct packed {
    logic phi1Set;
    logic phi2Set;
  } phaseStrobes_t;
endpackage

// File: rtl/stretch_datapath.sv
module stretch_datapath
  import cpu_clock_stretcher_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  phaseStrobes_t    strobes,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cntNext,
  output logic             phi1,
  output logic             phi2,
  output logic             sysClk2,
  output logic             sysClk1
);
  localparam int TAP_FAST = CNT_W - 2;  // 2 MHz tap
  localparam int TAP_SLOW = CNT_W - 1;  // 1 MHz tap

  assign cntNext = cnt + CNT_W'(1);

  // Every clock output is a flop so nothing reaches a pin through logic.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      phi1    <= 1'b0;
      phi2    <= 1'b0;
      sysClk2 <= 1'b0;
      sysClk1 <= 1'b0;
    end else begin
      cnt     <= cntNext;
      phi1    <= strobes.phi1Set;
      phi2    <= strobes.phi2Set;
      sysClk2 <= cntNext[TAP_FAST];
      sysClk1 <= cntNext[TAP_SLOW] ^ cntNext[TAP_FAST];
    end
  end
endmodule

// File: rtl/stretch_control.sv
module stretch_control
  import cpu_clock_stretcher_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int NUM_SEL = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SEL-1:0] slowSelN,
  input  logic [CNT_W-1:0]   cntNext,
  output phaseStrobes_t      strobes
);
  localparam int PH_W = CNT_W - 1;
  localparam logic [PH_W-1:0]  PH_P2_RISE = PH_W'(1);
  localparam logic [PH_W-1:0]  PH_MID     = PH_W'(1 << (PH_W - 1));
  localparam logic [PH_W-1:0]  PH_P1_RISE = PH_MID + PH_W'(1);
  localparam logic [CNT_W-1:0] CNT_E_RISE = CNT_W'(1 << (CNT_W - 2));
  localparam logic [CNT_W-1:0] CNT_E_FALL = CNT_W'(3 << (CNT_W - 2));

  logic [PH_W-1:0] phase;
  logic slowReq;
  logic reqLatch, reqLatchNext;
  logic stretch, stretchNext;
  logic seenRise, seenRiseNext;

  assign phase   = cntNext[PH_W-1:0];
  assign slowReq = ~(&slowSelN);

  always_comb begin
    // Stretch starts with phi2 of a requested cycle and ends on the
    // 1 MHz falling edge that closes a high phase seen while stretching.
    if (phase == PH_P2_RISE && reqLatch)
      stretchNext = 1'b1;
    else if (cntNext == CNT_E_FALL && seenRise)
      stretchNext = 1'b0;
    else
      stretchNext = stretch;

    if (!stretchNext)
      seenRiseNext = 1'b0;
    else if (cntNext == CNT_E_RISE && stretch)
      seenRiseNext = 1'b1;
    else
      seenRiseNext = seenRise;

    // Request captured only on the edge that opens phi1.
    if (phase == PH_P1_RISE && !stretchNext)
      reqLatchNext = slowReq;
    else
      reqLatchNext = reqLatch;

    strobes.phi2Set = stretchNext | ((phase >= PH_P2_RISE) && (phase < PH_MID));
    strobes.phi1Set = !stretchNext && (phase > PH_MID);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqLatch <= 1'b0;
      stretch  <= 1'b0;
      seenRise <= 1'b0;
    end else begin
      reqLatch <= reqLatchNext;
      stretch  <= stretchNext;
      seenRise <= seenRiseNext;
    end
  end
endmodule

// File: rtl/cpu_clock_stretcher.sv
module cpu_clock_stretcher
  import cpu_clock_stretcher_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int NUM_SEL = 6
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SEL-1:0] slowSelN,
  output logic [CNT_W-1:0]   divTaps,
  output logic               phi1,
  output logic               phi2,
  output logic               sysClk2,
  output logic               sysClk1
);
  phaseStrobes_t    strobes;
  logic [CNT_W-1:0] cntNext;

  stretch_control #(.CNT_W(CNT_W), .NUM_SEL(NUM_SEL)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .slowSelN (slowSelN),
    .cntNext  (cntNext),
    .strobes  (strobes)
  );

  stretch_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .cnt     (divTaps),
    .cntNext (cntNext),
    .phi1    (phi1),
    .phi2    (phi2),
    .sysClk2 (sysClk2),
    .sysClk1 (sysClk1)
  );
endmodule

// File: rtl/cpu_clock_stretcher_chk.sv
module cpu_clock_stretcher_chk #(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic [CNT_W-1:0] divTaps,
  input logic             phi1,
  input logic             phi2,
  input logic             sysClk2,
  input logic             sysClk1
);
  localparam int PH_W = CNT_W - 1;
  localparam logic [PH_W-1:0]  PH_ONE = PH_W'(1);
  localparam logic [PH_W-1:0]  PH_MID = PH_W'(1 << (PH_W - 1));
  localparam logic [CNT_W-1:0] CNT_E_RISE = CNT_W'(1 << (CNT_W - 2));
  localparam logic [CNT_W-1:0] CNT_E_FALL = CNT_W'(3 << (CNT_W - 2));

  logic [PH_W-1:0] phase;
  assign phase = divTaps[PH_W-1:0];

  p_count_step_r1: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> divTaps == CNT_W'($past(divTaps) + CNT_W'(1)));

  p_fast_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysClk2) |-> phase == PH_MID);

  p_slow_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysClk1) |-> divTaps == CNT_E_RISE);

  p_phi2_rise_grid_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(phi2) |-> phase == PH_ONE);

  p_phi1_rise_grid_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(phi1) |-> phase == PH_MID + PH_ONE);

  p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rstN)
    !(phi1 && phi2));

  p_dead_after_phi2_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(phi2) |-> !phi1);

  p_dead_after_phi1_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(phi1) |-> !phi2);

  p_phi2_fall_grid_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(phi2) |-> phase == PH_MID);

  p_shared_fall_r7: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(phi2) && divTaps == CNT_E_FALL) |-> $fell(sysClk1));

  p_stretch_holds_r8: assert property (@(posedge clk) disable iff (!rstN)
    (phi2 && phase > PH_MID) |=> (phi2 && !phi1));
endmodule

bind cpu_clock_stretcher cpu_clock_stretcher_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .divTaps (divTaps),
  .phi1    (phi1),
  .phi2    (phi2),
  .sysClk2 (sysClk2),
  .sysClk1 (sysClk1)
);

// File: tb/sim_cpu_clock_stretcher.sv
module sim_cpu_clock_stretcher;
  localparam int CNT_W   = 4;
  localparam int NUM_SEL = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NUM_SEL-1:0] slowSelN = '1;
  logic [CNT_W-1:0] divTaps;
  logic phi1, phi2, sysClk2, sysClk1;

  int checks = 0;
  int errors = 0;
  int caseA = 0;
  int caseB = 0;
  bit armed = 1'b0;
  bit done = 1'b0;

  typedef struct {
    int    rise;
    int    len;
    bit    shared;
    string tag;
  } expT;
  expT expQ[$];
  expT curExp;

  always #5 clk = ~clk;

  cpu_clock_stretcher #(.CNT_W(CNT_W), .NUM_SEL(NUM_SEL)) u0 (
    .clk      (clk),
    .rstN     (rstN),
    .slowSelN (slowSelN),
    .divTaps  (divTaps),
    .phi1     (phi1),
    .phi2     (phi2),
    .sysClk2  (sysClk2),
    .sysClk1  (sysClk1)
  );

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Monitor: measures each phi2 pulse and compares with the scoreboard.
  bit prevPhi1 = 0, prevPhi2 = 0, prevE = 0, inArmed = 0, overlap = 0, lastSlow = 0;
  int riseTap = 0, hiLen = 0;

  always @(negedge clk) begin
    if (!rstN) begin
      prevPhi1 = 0; prevPhi2 = 0; prevE = 0; inArmed = 0; overlap = 0; hiLen = 0;
    end else begin
      if (phi1 && phi2) overlap = 1;
      if (prevPhi2 && !phi2 && phi1) overlap = 1;
      if (prevPhi1 && !phi1 && phi2) overlap = 1;
      if (phi1 && !prevPhi1 && armed)
        check(int'(divTaps[CNT_W-2:0]) == 5, lastSlow ? "R8" : "R3",
              "phi1 rise phase", int'(divTaps[CNT_W-2:0]), 5);
      if (phi2 && !prevPhi2) begin
        riseTap = int'(divTaps);
        hiLen = 1;
        inArmed = armed;
      end else if (phi2) begin
        hiLen++;
      end
      if (!phi2 && prevPhi2 && inArmed) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R3", "unexpected phi2 pulse at count", riseTap, -1);
        end else begin
          curExp = expQ.pop_front();
          check(riseTap == curExp.rise, curExp.tag, "phi2 rise count", riseTap, curExp.rise);
          check(hiLen == curExp.len, curExp.tag, "phi2 high length", hiLen, curExp.len);
          check((prevE && !sysClk1) == curExp.shared, curExp.tag,
                "phi2 falls with 1MHz clock", int'(prevE && !sysClk1), int'(curExp.shared));
          check(!overlap, "R4", "phase overlap or missing dead time", int'(overlap), 0);
          lastSlow = (curExp.len > 3);
        end
        overlap = 0;
        inArmed = 0;
      end
      prevPhi1 = phi1; prevPhi2 = phi2; prevE = sysClk1;
    end
  end

  // Driver: kind 0 fast, 1 slow (R6/R7), 2 request raised after sampling (R5).
  task automatic doCycle(int kind, int sel);
    int tap;
    expT e;
    while (!(int'(divTaps[CNT_W-2:0]) == 4 && !phi2)) @(negedge clk);
    tap = int'(divTaps);
    e.rise = (tap == 12) ? 1 : 9;
    e.len = (kind == 1) ? ((tap == 12) ? 11 : 19) : 3;
    e.shared = (((e.rise + e.len) % 16) == 12);
    e.tag = (kind == 2) ? "R5" : (kind == 0) ? "R3" : (tap == 12) ? "R6" : "R7";
    if (kind == 1) begin
      if (tap == 12) caseA++;
      else caseB++;
    end
    expQ.push_back(e);
    armed = 1'b1;
    slowSelN = (kind == 1) ? ~(NUM_SEL'(1) << sel) : '1;
    @(negedge clk);
    slowSelN = (kind == 2) ? ~(NUM_SEL'(1) << sel) : '1;
    while (!phi2) @(negedge clk);
    while (phi2) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: everything low in reset
    check(divTaps == 0, "R9", "divTaps in reset", int'(divTaps), 0);
    check(!phi1 && !phi2, "R9", "phases in reset", int'({phi1, phi2}), 0);
    check(!sysClk1 && !sysClk2, "R9", "system clocks in reset", int'({sysClk1, sysClk2}), 0);
    rstN = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      check(int'(divTaps) == (i + 1) % 16, "R1", "divider count", int'(divTaps), (i + 1) % 16);
      check(sysClk2 == divTaps[2], "R2", "2MHz clock vs tap", int'(sysClk2), int'(divTaps[2]));
      check(sysClk1 == (divTaps >= 4 && divTaps <= 11), "R2", "1MHz clock window",
            int'(sysClk1), int'(divTaps >= 4 && divTaps <= 11));
    end
    doCycle(1, 0);
    doCycle(0, 0);
    doCycle(1, 1);
    doCycle(1, 2);
    doCycle(0, 0);
    doCycle(0, 0);
    doCycle(2, 3);
    doCycle(1, 4);
    doCycle(0, 0);
    doCycle(1, 5);
    doCycle(2, 0);
    doCycle(0, 0);
    doCycle(1, 1);
    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R3", "pending expected pulses", expQ.size(), 0);
    check(caseA > 0, "R6", "stretches entered with 1MHz clock low", caseA, 1);
    check(caseB > 0, "R7", "stretches entered with 1MHz clock high", caseB, 1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule